// File: doc/BRIEF.md
# PWM Channel Run and Interrupt Control Registers

This block is the shared control and status register set of a four-channel pulse-width modulator. It sits on a simple memory-mapped bus that carries an address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe. The block drives a per-channel run enable toward the channel counters. It takes in a one-cycle end-of-period pulse from each channel and drives a single interrupt line. It also holds a plain 32-bit mode word, which it passes out unchanged to the clock dividers; those dividers sit outside the block.

The run enables and the interrupt masks have no writable register of their own. Software turns bits on by writing ones to one offset and turns them off by writing ones to a second offset; zero bits in either write leave the state alone. A separate read-only offset shows the current value. End-of-period pulses are latched as pending bits. Reading the pending register returns the bits and acknowledges them in the same access. A pulse that arrives during that read is kept pending for the next read. The interrupt line is high while any pending bit also has its mask bit set.

Top module: `pwmctl_regs`

## Requirements
- R1: After reset, the run enables, interrupt masks, pending bits and mode word are all zero, and `irq_o` is low.
- R2: A write to offset 0x04 sets every channel enable whose data bit is 1 and leaves the others unchanged. `ch_en_o` and a read of offset 0x0C both show the new enables from the cycle after the write.
- R3: A write to offset 0x08 clears every channel enable whose data bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x10 sets mask bits and a write to offset 0x14 clears mask bits, with the same one-bit-per-channel rule. The mask reads back at offset 0x18. Writes to 0x18 are ignored.
- R5: A one-cycle pulse on `period_end_i[n]` sets pending bit n, and the bit stays set until it is acknowledged.
- R6: A read of offset 0x1C returns the pending bits held before that cycle and clears them.
- R7: A period-end pulse in the same cycle as a read of 0x1C is not returned by that read. It stays pending and is returned by the next read.
- R8: `irq_o` is high exactly when some pending bit has its mask bit set. Clearing the mask, or acknowledging the pending bits, drops it.
- R9: Bits 4 to 31 of the enable, status, mask and pending views always read zero. Write data in those bits has no effect. Writes to the read-only offsets 0x0C and 0x1C change nothing.
- R10: The mode word at offset 0x00 is read/write over all 32 bits and drives `div_cfg_o` from the cycle after the write.
- R11: `bus_rdata` is updated one cycle after `bus_rd`. A read of an unmapped offset returns zero.
- R12: Writing 0xF to offset 0x08 and then to 0x14 turns off every channel enable and every mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| period_end_i | input | 4 | Per-channel end-of-period pulses |
| ch_en_o | output | 4 | Per-channel run enables |
| div_cfg_o | output | 32 | Mode word for the clock dividers |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a period-end pulse that lands in the same clock cycle as the acknowledging read of the pending register. The bench raises the pulse and the read strobe on the same falling edge. It then checks that the read returns only the bits that were already pending, and that a second read returns the new bit. The interrupt line is checked on both sides of that acknowledge while the mask holds the channel enabled.

// File: rtl/pwmctl_pkg.sv
package pwmctl_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_RUN  = 8'h04;
  localparam logic [7:0] OFS_STOP = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_IDIS = 8'h14;
  localparam logic [7:0] OFS_MASK = 8'h18;
  localparam logic [7:0] OFS_PEND = 8'h1C;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_MODE, RSEL_STAT, RSEL_MASK, RSEL_PEND
  } rsel_e;
endpackage

// File: rtl/pwmctl_decode.sv
module pwmctl_decode
  import pwmctl_pkg::*;
(
  input  logic [7:0] addr,
  input  logic       wr,
  input  logic       rd,
  output logic       we_mode,
  output logic       we_run,
  output logic       we_stop,
  output logic       we_ien,
  output logic       we_idis,
  output logic       rd_ack,
  output rsel_e      rsel
);
  always_comb begin
    we_mode = wr && (addr == OFS_MODE);
    we_run  = wr && (addr == OFS_RUN);
    we_stop = wr && (addr == OFS_STOP);
    we_ien  = wr && (addr == OFS_IEN);
    we_idis = wr && (addr == OFS_IDIS);
    rd_ack  = rd && (addr == OFS_PEND);
    unique case (addr)
      OFS_MODE: rsel = RSEL_MODE;
      OFS_STAT: rsel = RSEL_STAT;
      OFS_MASK: rsel = RSEL_MASK;
      OFS_PEND: rsel = RSEL_PEND;
      default:  rsel = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/pwmctl_setclr.sv
module pwmctl_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_bits(
    input logic [W-1:0] cur, input logic s, input logic c, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | b;
    if (c) r = r & ~b;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_bits(q, set_stb, clr_stb, bits);
  end

  // R2 / R4: set strobe turns on every selected bit
  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((q & $past(bits)) == $past(bits)));
  // R3 / R4: clear strobe turns off every selected bit
  p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((q & $past(bits)) == '0));
  // R2: without a strobe the bits hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/pwmctl_pending.sv
module pwmctl_pending #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         ack,
  output logic [W-1:0] pend
);
  function automatic logic [W-1:0] next_pend(
    input logic [W-1:0] cur, input logic [W-1:0] e, input logic a);
    return (a ? '0 : cur) | e;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= next_pend(pend, ev, ack);
  end

  // R5: a pulse always leaves its bit pending
  p_event_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));
  // R6 / R7: after an acknowledge only same-cycle pulses remain
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (pend == $past(ev)));
  // R5: without pulse or acknowledge the bits hold
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && ev == '0) |=> $stable(pend));
endmodule

// File: rtl/pwmctl_regs.sv
module pwmctl_regs
  import pwmctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] period_end_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [DATA_W-1:0] div_cfg_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NUM_CH;

  logic we_mode, we_run, we_stop, we_ien, we_idis, rd_ack;
  rsel_e rsel;
  logic [NUM_CH-1:0] run_q, mask_q, pend_q, hit;
  logic [DATA_W-1:0] mode_q;

  pwmctl_decode u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .we_mode(we_mode), .we_run(we_run), .we_stop(we_stop),
    .we_ien(we_ien), .we_idis(we_idis), .rd_ack(rd_ack), .rsel(rsel)
  );

  pwmctl_setclr #(.W(NUM_CH)) u_run (
    .clk(clk), .rst_n(rst_n), .set_stb(we_run), .clr_stb(we_stop),
    .bits(bus_wdata[NUM_CH-1:0]), .q(run_q)
  );

  pwmctl_setclr #(.W(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_stb(we_ien), .clr_stb(we_idis),
    .bits(bus_wdata[NUM_CH-1:0]), .q(mask_q)
  );

  pwmctl_pending #(.W(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .ev(period_end_i), .ack(rd_ack), .pend(pend_q)
  );

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_CH-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (we_mode) mode_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (rsel)
        RSEL_MODE: bus_rdata <= mode_q;
        RSEL_STAT: bus_rdata <= widen(run_q);
        RSEL_MASK: bus_rdata <= widen(mask_q);
        RSEL_PEND: bus_rdata <= widen(pend_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assign hit       = pend_q & mask_q;
  assign irq_o     = |hit;
  assign ch_en_o   = run_q;
  assign div_cfg_o = mode_q;

  // R8: no mask bit, no interrupt
  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  // R8: no pending bit, no interrupt
  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq_o);
  // R11: unmapped reads return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rsel == RSEL_NONE) |=> (bus_rdata == '0));
  // R9: upper bits of channel views stay zero
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rsel != RSEL_MODE) |=> (bus_rdata[DATA_W-1:NUM_CH] == '0));
  // R10: the mode word changes only by a write to its offset
  p_mode_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_mode |=> $stable(div_cfg_o));
endmodule

// File: tb/pwmctl_regs_tb.sv
module pwmctl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  period_end_i = '0;
  logic [3:0]  ch_en_o;
  logic [31:0] div_cfg_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .period_end_i(period_end_i), .ch_en_o(ch_en_o), .div_cfg_o(div_cfg_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] p);
    @(negedge clk); period_end_i = p;
    @(negedge clk); period_end_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ch_en_o", {28'd0, ch_en_o}, 32'd0);
    chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
    chk("R1 div_cfg_o", div_cfg_o, 32'd0);
    rd(8'h18, d); chk("R1 mask", d, 32'd0);
    rd(8'h1C, d); chk("R1 pending", d, 32'd0);
  endtask

  task automatic t_run_stop();
    logic [31:0] d;
    wr(8'h04, 32'h5);  chk("R2 ch_en after set 5", {28'd0, ch_en_o}, 32'h5);
    wr(8'h04, 32'h2);  chk("R2 set keeps others", {28'd0, ch_en_o}, 32'h7);
    rd(8'h0C, d);      chk("R2 status read", d, 32'h7);
    wr(8'h08, 32'h4);  chk("R3 clear bit2", {28'd0, ch_en_o}, 32'h3);
    wr(8'h08, 32'h0);  chk("R3 zero clear no effect", {28'd0, ch_en_o}, 32'h3);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h10, 32'hC); rd(8'h18, d); chk("R4 mask set", d, 32'hC);
    wr(8'h14, 32'h8); rd(8'h18, d); chk("R4 mask clear", d, 32'h4);
    wr(8'h18, 32'hF); rd(8'h18, d); chk("R4 mask write ignored", d, 32'h4);
  endtask

  task automatic t_pend_irq();
    logic [31:0] d;
    pulse(4'h1);
    chk("R8 unmasked pending no irq", {31'd0, irq_o}, 32'd0);
    pulse(4'h4);
    chk("R8 masked pending irq", {31'd0, irq_o}, 32'd1);
    wr(8'h14, 32'h4);
    chk("R8 irq drops with mask", {31'd0, irq_o}, 32'd0);
    wr(8'h10, 32'h4);
    chk("R8 irq back with mask", {31'd0, irq_o}, 32'd1);
    rd(8'h1C, d); chk("R5 R6 pending read", d, 32'h5);
    chk("R8 irq drops after ack", {31'd0, irq_o}, 32'd0);
    rd(8'h1C, d); chk("R6 pending cleared", d, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    pulse(4'h1);
    @(negedge clk); bus_addr = 8'h1C; bus_rd = 1'b1; period_end_i = 4'h4;
    @(negedge clk); bus_rd = 1'b0; period_end_i = '0; d = bus_rdata;
    chk("R7 read excludes same-cycle pulse", d, 32'h1);
    chk("R7 irq from kept pulse", {31'd0, irq_o}, 32'd1);
    rd(8'h1C, d); chk("R7 kept pulse next read", d, 32'h4);
  endtask

  task automatic t_upper();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFF0); rd(8'h0C, d); chk("R9 upper set ignored", d, 32'h3);
    wr(8'h0C, 32'hF);         rd(8'h0C, d); chk("R9 status write ignored", d, 32'h3);
    pulse(4'h2);
    wr(8'h1C, 32'h0);         rd(8'h1C, d); chk("R9 pending write ignored", d, 32'h2);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(8'h00, 32'hA5C3_0F17);
    chk("R10 div_cfg_o", div_cfg_o, 32'hA5C3_0F17);
    rd(8'h00, d); chk("R10 mode read", d, 32'hA5C3_0F17);
    rd(8'h24, d); chk("R11 unmapped read zero", d, 32'h0);
    @(negedge clk); bus_addr = 8'h0C; bus_rd = 1'b1;
    #1 chk("R11 rdata not yet updated", bus_rdata, 32'h0);
    @(negedge clk); bus_rd = 1'b0;
    chk("R11 rdata after one cycle", bus_rdata, 32'h3);
  endtask

  task automatic t_shutdown();
    logic [31:0] d;
    wr(8'h04, 32'hF); wr(8'h10, 32'hF);
    wr(8'h08, 32'hF); wr(8'h14, 32'hF);
    chk("R12 all channels off", {28'd0, ch_en_o}, 32'h0);
    rd(8'h18, d); chk("R12 all masks off", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_stop();
    t_mask();
    t_pend_irq();
    t_same_cycle();
    t_upper();
    t_mode();
    t_shutdown();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule